// File: doc/BRIEF.md
# Banked GPIO Edge-Interrupt Controller

This block is a register-mapped general-purpose I/O controller with two pin banks, a core bank and a resume bank. The pin count of each bank is a parameter. Every pin has its own settings for enable, direction, output level, rising-edge trigger and falling-edge trigger. It also has an event-enable mask bit, a routing-select bit that is stored only, and a sticky trigger-status bit.

Pad inputs pass through a two-flop synchronizer. The block then detects the edges selected for each pin and latches them into status bits. Software clears a status bit by writing 1 to it. A single level-type event output stays high while any unmasked pin in either bank has its status set.

Software writes one byte at a time through a byte-addressed port. A read returns the whole 32-bit register that contains the addressed byte, so an interrupt handler can collect all pending pins of a bank in one access. Tri-state control for each pad is brought out as an output-enable vector next to the output-level vector.

Top module: `bank_gpio_irq`

## Requirements
- R1: Address bit 5 selects the bank (0 = core, 1 = resume). Address bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising trigger, 4 falling trigger, 5 event enable, 6 routing select, 7 trigger status. Address bits 1:0 select the byte lane. Pin p of a bank is bit p mod 8 of lane p/8. A write changes only the pins of the addressed lane that exist in that bank.
- R2: After reset, the direction register reads all ones for the existing pins. Every other register reads zero, and the event output and all output enables are low.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. A pad's output enable is high only when the pin is enabled and is an output. Its output value is then the stored level latch; otherwise the output value is 0.
- R4: For an input pin, the level register reads the synchronized pad value. For an output pin it reads the stored latch. Writing the level of an input pin changes the latch without driving the pad.
- R5: A pin with its rising-trigger bit set captures a 0-to-1 pad change, and a pin with its falling-trigger bit set captures a 1-to-0 change. With both bits set the pin captures either edge, and with neither set it captures nothing. The status bit reads 1 after the third rising clock edge that follows the pad change.
- R6: Writing 1 to a trigger-status bit clears it. Writing 0 leaves it unchanged.
- R7: If a qualifying edge is captured in the same cycle as a write of 1 to that pin's status bit, the bit stays set.
- R8: The event output is high while any pin in either bank has both its status bit and its event-enable bit set. A pin whose event-enable bit is 0 still latches status but does not raise the event.
- R9: A pin whose enable bit is 0 captures no edges and has its output enable low.
- R10: A read returns the full 32-bit register selected by address bits 5:2, whatever the value of bits 1:0. Bits above the bank's pin count read 0.
- R11: The routing-select register stores and reads back its value and has no effect on the pins or the event output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address |
| busWe | input | 1 | Write strobe for one byte |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 32 | Whole register containing the addressed byte |
| corePadIn | input | CORE_PINS | Core bank pad inputs |
| corePadOut | output | CORE_PINS | Core bank pad output values |
| corePadOe | output | CORE_PINS | Core bank pad output enables |
| resPadIn | input | RESUME_PINS | Resume bank pad inputs |
| resPadOut | output | RESUME_PINS | Resume bank pad output values |
| resPadOe | output | RESUME_PINS | Resume bank pad output enables |
| eventOut | output | 1 | Level-type summary event |

## Verification
The bench builds the block with its default sizes: 12 core pins and 9 resume pins. With 12 core pins, the core bank uses a full first lane and a partial second lane, so lane selection and the zeroing of pins that do not exist are both exercised. With 9 resume pins, a single pin sits in the second lane and a write to the third lane must be ignored. Using two different widths also checks that the banks stay independent of each other, that the event output combines both banks, and that the same-cycle race between a status clear and a new edge is tested on a pin in the upper lane.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    REG_EN  = 3'd0,
    REG_DIR = 3'd1,
    REG_LVL = 3'd2,
    REG_RISE = 3'd3,
    REG_FALL = 3'd4,
    REG_MASK = 3'd5,
    REG_ROUTE = 3'd6,
    REG_STS = 3'd7
  } regId_e;

  // Strobes from the bus decoder to each bank datapath
  typedef struct packed {
    logic       wrEn;
    logic       bankSel;
    regId_e     regIdx;
    logic [1:0] lane;
    logic [7:0] data;
  } busStrobe_t;

endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [5:0]  busAddr,
  input  logic        busWe,
  input  logic [7:0]  busWdata,
  input  logic [31:0] coreRdWord,
  input  logic [31:0] resRdWord,
  output busStrobe_t  strobe,
  output logic [31:0] busRdata
);

  always_comb begin
    strobe.wrEn    = busWe;
    strobe.bankSel = busAddr[5];
    strobe.regIdx  = regId_e'(busAddr[4:2]);
    strobe.lane    = busAddr[1:0];
    strobe.data    = busWdata;
  end

  // Whole-word read: lane bits do not narrow the returned data
  assign busRdata = busAddr[5] ? resRdWord : coreRdWord;

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_irq_pkg::*;
#(
  parameter int   PINS     = 8,
  parameter logic BANK_SEL = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  busStrobe_t      strobe,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [31:0]     rdWord,
  output logic            eventHit
);

  logic [PINS-1:0] enReg, dirReg, lvlReg, riseReg, fallReg, maskReg, routeReg, stsReg;
  logic [PINS-1:0] syncA, syncB, prevB;
  logic [PINS-1:0] laneMask, wrBits, clrMask, edgeHit, lvlView;
  logic            bankWr;

  assign bankWr = strobe.wrEn && (strobe.bankSel == BANK_SEL);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign laneMask[i] = (strobe.lane == 2'(i / 8));
    assign wrBits[i]   = strobe.data[i % 8];
  end

  assign clrMask = (bankWr && strobe.regIdx == REG_STS) ? (laneMask & wrBits) : '0;
  assign edgeHit = enReg & ((riseReg & syncB & ~prevB) | (fallReg & ~syncB & prevB));
  assign lvlView = (dirReg & syncB) | (~dirReg & lvlReg);
  assign padOe   = enReg & ~dirReg;
  assign padOut  = lvlReg & padOe;
  assign eventHit = |(stsReg & maskReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      dirReg   <= '1;
      lvlReg   <= '0;
      riseReg  <= '0;
      fallReg  <= '0;
      maskReg  <= '0;
      routeReg <= '0;
      stsReg   <= '0;
    end else begin
      if (bankWr) begin
        case (strobe.regIdx)
          REG_EN:    enReg    <= (enReg & ~laneMask) | (wrBits & laneMask);
          REG_DIR:   dirReg   <= (dirReg & ~laneMask) | (wrBits & laneMask);
          REG_LVL:   lvlReg   <= (lvlReg & ~laneMask) | (wrBits & laneMask);
          REG_RISE:  riseReg  <= (riseReg & ~laneMask) | (wrBits & laneMask);
          REG_FALL:  fallReg  <= (fallReg & ~laneMask) | (wrBits & laneMask);
          REG_MASK:  maskReg  <= (maskReg & ~laneMask) | (wrBits & laneMask);
          REG_ROUTE: routeReg <= (routeReg & ~laneMask) | (wrBits & laneMask);
          default:   ;
        endcase
      end
      // Capture has priority over a same-cycle clear
      stsReg <= (stsReg & ~clrMask) | edgeHit;
    end
  end

  always_comb begin
    rdWord = '0;
    case (strobe.regIdx)
      REG_EN:    rdWord[PINS-1:0] = enReg;
      REG_DIR:   rdWord[PINS-1:0] = dirReg;
      REG_LVL:   rdWord[PINS-1:0] = lvlView;
      REG_RISE:  rdWord[PINS-1:0] = riseReg;
      REG_FALL:  rdWord[PINS-1:0] = fallReg;
      REG_MASK:  rdWord[PINS-1:0] = maskReg;
      REG_ROUTE: rdWord[PINS-1:0] = routeReg;
      default:   rdWord[PINS-1:0] = stsReg;
    endcase
  end

  // R5: a captured edge is visible in status on the next cycle
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> ((stsReg & $past(edgeHit)) == $past(edgeHit)));

  // R6: write-one clears when no edge competes
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrMask & ~edgeHit)) |=> ((stsReg & $past(clrMask & ~edgeHit)) == '0));

  // R7: a competing edge keeps the bit set
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrMask & edgeHit)) |=> ((stsReg & $past(clrMask & edgeHit)) == $past(clrMask & edgeHit)));

  // R9: no newly set status bit on a disabled pin
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stsReg & ~$past(stsReg) & ~$past(enReg)) == '0));

endmodule

// File: rtl/bank_gpio_irq.sv
module bank_gpio_irq
  import gpio_irq_pkg::*;
#(
  parameter int CORE_PINS   = 12,
  parameter int RESUME_PINS = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [5:0]             busAddr,
  input  logic                   busWe,
  input  logic [7:0]             busWdata,
  output logic [31:0]            busRdata,
  input  logic [CORE_PINS-1:0]   corePadIn,
  output logic [CORE_PINS-1:0]   corePadOut,
  output logic [CORE_PINS-1:0]   corePadOe,
  input  logic [RESUME_PINS-1:0] resPadIn,
  output logic [RESUME_PINS-1:0] resPadOut,
  output logic [RESUME_PINS-1:0] resPadOe,
  output logic                   eventOut
);

  busStrobe_t  strobe;
  logic [31:0] coreRdWord, resRdWord;
  logic        coreHit, resHit;

  gpio_bus_ctrl u_ctrl (
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .coreRdWord (coreRdWord),
    .resRdWord  (resRdWord),
    .strobe     (strobe),
    .busRdata   (busRdata)
  );

  gpio_pin_bank #(.PINS(CORE_PINS), .BANK_SEL(1'b0)) u_core (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .padIn    (corePadIn),
    .padOut   (corePadOut),
    .padOe    (corePadOe),
    .rdWord   (coreRdWord),
    .eventHit (coreHit)
  );

  gpio_pin_bank #(.PINS(RESUME_PINS), .BANK_SEL(1'b1)) u_resume (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .padIn    (resPadIn),
    .padOut   (resPadOut),
    .padOe    (resPadOe),
    .rdWord   (resRdWord),
    .eventHit (resHit)
  );

  assign eventOut = coreHit | resHit;

  // R8: the level event can only drop after a bus write
  assert_event_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eventOut && !busWe) |=> eventOut);

endmodule

// File: tb/bank_gpio_irq_test.sv
module bank_gpio_irq_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NCORE = 12;
  localparam int  NRES  = 9;

  typedef struct packed {
    logic        isWr;
    logic [5:0]  addr;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 6'h00, 32'h000, 4'd2},   // R2 enable resets to zero
    '{1'b0, 6'h04, 32'hFFF, 4'd2},   // R2 core direction all inputs
    '{1'b0, 6'h24, 32'h1FF, 4'd2},   // R2 resume direction all inputs
    '{1'b0, 6'h1C, 32'h000, 4'd2},   // R2 core status clear
    '{1'b0, 6'h3C, 32'h000, 4'd2},   // R2 resume status clear
    '{1'b1, 6'h01, 32'h0FF, 4'd1},   // R1 lane 1 of core enable
    '{1'b0, 6'h00, 32'hF00, 4'd1},   // R1 only pins 8..11 exist
    '{1'b1, 6'h00, 32'h05A, 4'd1},   // R1 lane 0
    '{1'b0, 6'h02, 32'hF5A, 4'd10},  // R10 whole word from any lane
    '{1'b1, 6'h21, 32'h0FF, 4'd1},   // R1 resume lane 1
    '{1'b0, 6'h20, 32'h100, 4'd1},   // R1 single pin in lane 1
    '{1'b1, 6'h18, 32'h03C, 4'd11},  // R11 routing select storage
    '{1'b0, 6'h18, 32'h03C, 4'd11},  // R11
    '{1'b1, 6'h38, 32'h081, 4'd11},  // R11 resume routing
    '{1'b0, 6'h3B, 32'h081, 4'd10},  // R10 read via lane 3
    '{1'b1, 6'h22, 32'h0FF, 4'd1},   // R1 lane beyond pins ignored
    '{1'b0, 6'h20, 32'h100, 4'd1}    // R1
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [5:0]       busAddr = '0;
  logic             busWe = 1'b0;
  logic [7:0]       busWdata = '0;
  logic [31:0]      busRdata;
  logic [NCORE-1:0] corePadIn = '0;
  logic [NCORE-1:0] corePadOut, corePadOe;
  logic [NRES-1:0]  resPadIn = '0;
  logic [NRES-1:0]  resPadOut, resPadOe;
  logic             eventOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bank_gpio_irq #(.CORE_PINS(NCORE), .RESUME_PINS(NRES)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .corePadIn(corePadIn), .corePadOut(corePadOut),
    .corePadOe(corePadOe), .resPadIn(resPadIn), .resPadOut(resPadOut),
    .resPadOe(resPadOe), .eventOut(eventOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge
  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 event after reset", 32'(eventOut), 32'h0);
    check("R2 core oe after reset", 32'(corePadOe), 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k].isWr) busWrite(VEC[k].addr, VEC[k].val[7:0]);
      else begin
        busRead(VEC[k].addr, rd);
        check($sformatf("R%0d vector %0d", VEC[k].req, k), rd, VEC[k].val);
      end
    end

    // Enable everything for the edge tests
    busWrite(6'h00, 8'hFF);
    busWrite(6'h01, 8'h0F);
    busWrite(6'h20, 8'hFF);

    // R5 rising edge on core pin 2
    busWrite(6'h0C, 8'h04);
    corePadIn[2] = 1'b1;
    settle();
    busRead(6'h1C, rd); check("R5 rising capture", rd, 32'h004);
    check("R8 masked pin no event", 32'(eventOut), 32'h0);
    busWrite(6'h14, 8'h04);
    check("R8 unmasked raises event", 32'(eventOut), 32'h1);
    busWrite(6'h1C, 8'h00);
    busRead(6'h1C, rd); check("R6 write zero keeps status", rd, 32'h004);
    busWrite(6'h1C, 8'h04);
    busRead(6'h1C, rd); check("R6 write one clears", rd, 32'h000);
    check("R8 event drops", 32'(eventOut), 32'h0);
    corePadIn[2] = 1'b0;
    settle();
    busRead(6'h1C, rd); check("R5 falling ignored when rise only", rd, 32'h000);

    // R5 falling edge on resume pin 3
    busWrite(6'h30, 8'h08);
    resPadIn[3] = 1'b1;
    settle();
    busRead(6'h3C, rd); check("R5 rising ignored when fall only", rd, 32'h000);
    resPadIn[3] = 1'b0;
    settle();
    busRead(6'h3C, rd); check("R5 falling capture resume", rd, 32'h008);
    busWrite(6'h34, 8'h08);
    check("R8 resume bank raises event", 32'(eventOut), 32'h1);
    busWrite(6'h3C, 8'h08);
    check("R8 resume event drops", 32'(eventOut), 32'h0);

    // R5 both edges on core pin 9, then R7 race
    busWrite(6'h0D, 8'h02);
    busWrite(6'h11, 8'h02);
    corePadIn[9] = 1'b1;
    settle();
    busRead(6'h1C, rd); check("R5 both edges rising", rd, 32'h200);
    busWrite(6'h1D, 8'h02);
    corePadIn[9] = 1'b0;
    settle();
    busRead(6'h1C, rd); check("R5 both edges falling", rd, 32'h200);
    corePadIn[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWrite(6'h1D, 8'h02);   // lands on the capture edge
    busRead(6'h1C, rd); check("R7 edge wins over clear", rd, 32'h200);
    busWrite(6'h1D, 8'h02);
    busRead(6'h1C, rd); check("R7 later clear works", rd, 32'h000);

    // R5 neither edge on core pin 5
    corePadIn[5] = 1'b1;
    settle();
    corePadIn[5] = 1'b0;
    settle();
    busRead(6'h1C, rd); check("R5 no trigger no capture", rd, 32'h000);

    // R9 disabled pin 11
    busWrite(6'h01, 8'h07);
    busWrite(6'h0D, 8'h0A);
    corePadIn[11] = 1'b1;
    settle();
    busRead(6'h1C, rd); check("R9 disabled pin no capture", rd, 32'h000);

    // R3 / R4 direction and level
    busWrite(6'h04, 8'hFE);
    busWrite(6'h08, 8'h01);
    check("R3 output pin oe", 32'(corePadOe[0]), 32'h1);
    check("R3 output pin value", 32'(corePadOut[0]), 32'h1);
    check("R3 input pin oe low", 32'(corePadOe[1]), 32'h0);
    corePadIn[1] = 1'b1;
    settle();
    busRead(6'h08, rd); check("R4 level read mixed", rd & 32'h3, 32'h3);
    busWrite(6'h08, 8'h02);
    busRead(6'h08, rd); check("R4 input shows pad latch hidden", rd & 32'h3, 32'h2);
    check("R4 input latch not driven", 32'(corePadOut[1]), 32'h0);
    corePadIn[1] = 1'b0;
    settle();
    busRead(6'h08, rd); check("R4 input follows pad", rd & 32'h2, 32'h0);
    busWrite(6'h04, 8'hFC);
    busRead(6'h08, rd); check("R4 output shows latch", rd & 32'h2, 32'h2);
    check("R3 pin becomes output", 32'(corePadOe[1]), 32'h1);
    check("R3 latch drives pad", 32'(corePadOut[1]), 32'h1);
    busWrite(6'h00, 8'hFD);
    check("R9 disabled pin oe low", 32'(corePadOe[1]), 32'h0);
    check("R11 routing has no event effect", 32'(eventOut), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule